// File: doc/BRIEF.md
# Double-Buffered Nibble-Loaded Converter Front End

This block is the digital side of a 12-bit digital-to-analog converter. A host writes a 12-bit code in up to three 4-bit pieces into a first rank of holding registers. It then moves the assembled word into a second, output rank, whose contents drive the converter. A bus of 4, 8, 12 or 16 bits can feed it, and the data may be placed left- or right-justified on that bus. Because the output rank changes only when its own select is active, the converter never sees a half-assembled word.

The control inputs are a write strobe, three nibble selects and one output-load select, all active low and all asynchronous to the system clock. The block samples them through a two-flop synchronizer and copies the behaviour of level-sensitive latches. While a register's select and the strobe are both low, it follows its input on every clock. It freezes on the first clock after either signal rises. A nibble write combined with the load select in the same strobe passes the new nibble straight through to the output rank. The final piece of a word and the transfer therefore happen in one write. A static mode input can present the output as straight binary, offset binary or two's complement, and a one-cycle pulse marks each change of the output rank.

Top module: `nib_dac_front`

## Requirements
- R1: While rst_ni is low and after it rises, code_o reads 0x000 and upd_o is low until the first write; all three nibble registers clear to zero.
- R2: Nibble register A holds bus bits 11..8, B holds bits 7..4 and C holds bits 3..0. A register follows its bus slice while the strobe and its own select are both low, and holds the last value seen after either signal rises.
- R3: While wr_ni is high, no register changes, whatever the selects and the data bus do.
- R4: The output rank takes the first-rank word while load_ni and wr_ni are both low, and holds it otherwise. Nibble writes made without load_ni leave code_o unchanged.
- R5: A nibble select and load_ni asserted in the same strobe place the new nibble and the previously stored nibbles in the output rank together. The output changes once, straight from the old word to the complete new word.
- R6: With wr_ni, all three nibble selects and load_ni all low, every register is transparent, and code_o tracks data_i while the condition holds.
- R7: code_mode_i 2'b00 (straight) and 2'b01 (offset binary, 0x800 = zero) pass the output rank unchanged. 2'b10 (two's complement) inverts bit 11 only. 2'b11 acts as 2'b00.
- R8: upd_o is high for exactly one cycle each time the output rank takes a value different from the one it held. Reloading the same value gives no pulse.
- R9: Control and data inputs pass through two synchronizer flops. An input change made between two rising edges appears at code_o after the third rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| sel_a_ni | input | 1 | Select for nibble A (bits 11..8), active low |
| sel_b_ni | input | 1 | Select for nibble B (bits 7..4), active low |
| sel_c_ni | input | 1 | Select for nibble C (bits 3..0), active low |
| load_ni | input | 1 | Output-rank load select, active low |
| data_i | input | 12 | Data bus |
| code_mode_i | input | 2 | Static output coding mode |
| code_o | output | 12 | Converter code |
| upd_o | output | 1 | One-cycle pulse when the output rank changes |

## Verification
Four kinds of property are checked on every cycle. The first rank never moves while the sampled strobe is high. An enabled nibble takes its bus slice. The output rank holds whenever the strobe or the load select is high. The update pulse matches a real change of the output rank. Only the directed scenarios can show the remaining behaviour. These are:
- that a nibble sequence ending with a combined nibble-and-load write makes exactly one output change;
- the full transparent mode;
- the exact three-edge latency;
- the code conversion in each coding mode.

// File: rtl/nib_dac_pkg.sv
package nib_dac_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NUM_NIB = 3;
  localparam int unsigned WORD_W  = NIB_W * NUM_NIB;

  typedef enum logic [1:0] {
    CODE_STRAIGHT = 2'b00,
    CODE_OFFSET   = 2'b01,
    CODE_TWOS     = 2'b10,
    CODE_SPARE    = 2'b11
  } code_mode_e;
endpackage

// File: rtl/nib_dac_sync.sv
module nib_dac_sync #(
  parameter int unsigned  W      = 8,
  parameter int unsigned  STAGES = 2,
  parameter logic [W-1:0] RST_V  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_V;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nib_dac_rank1.sv
module nib_dac_rank1 #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NUM_NIB = 3,
  localparam int unsigned WORD_W = NIB_W * NUM_NIB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_ni,
  input  logic [NUM_NIB-1:0] sel_ni,   // index 0 = least significant nibble
  input  logic [WORD_W-1:0]  data_i,
  output logic [WORD_W-1:0]  word_o,   // stored first-rank word
  output logic [WORD_W-1:0]  pass_o    // word as seen through open latches
);
  logic [NUM_NIB-1:0] nib_en;

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    logic [NIB_W-1:0] nib_q;

    assign nib_en[g] = ~(wr_ni | sel_ni[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        nib_q <= '0;
      else if (nib_en[g]) nib_q <= data_i[g*NIB_W +: NIB_W];
    end

    assign word_o[g*NIB_W +: NIB_W] = nib_q;
    // open nibble feeds the output rank in the same cycle
    assign pass_o[g*NIB_W +: NIB_W] = nib_en[g] ? data_i[g*NIB_W +: NIB_W] : nib_q;

    // R2
    nib_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nib_en[g] |=> nib_q == $past(data_i[g*NIB_W +: NIB_W]));
  end

  // R3
  wr_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(word_o));
endmodule

// File: rtl/nib_dac_rank2.sv
module nib_dac_rank2 #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              load_ni,
  input  logic [WORD_W-1:0] pass_i,
  output logic [WORD_W-1:0] out_o,
  output logic              upd_o
);
  logic              ld_en;
  logic [WORD_W-1:0] out_q;
  logic              upd_q;

  assign ld_en = ~(wr_ni | load_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= ld_en && (pass_i != out_q);
      if (ld_en) out_q <= pass_i;
    end
  end

  assign out_o = out_q;
  assign upd_o = upd_q;

  // R4
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni || load_ni) |=> $stable(out_q));

  // R8
  upd_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q == (out_q != $past(out_q)));
endmodule

// File: rtl/nib_dac_front.sv
module nib_dac_front
  import nib_dac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              sel_a_ni,
  input  logic              sel_b_ni,
  input  logic              sel_c_ni,
  input  logic              load_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic [1:0]        code_mode_i,
  output logic [WORD_W-1:0] code_o,
  output logic              upd_o
);
  localparam int unsigned CTL_W = NUM_NIB + 2;
  localparam int unsigned SYN_W = CTL_W + WORD_W;
  localparam logic [SYN_W-1:0] SYN_RST = {{CTL_W{1'b1}}, {WORD_W{1'b0}}};

  logic [SYN_W-1:0]   raw, syn;
  logic               s_wr_n, s_load_n;
  logic [NUM_NIB-1:0] s_sel_n;
  logic [WORD_W-1:0]  s_data;
  logic [WORD_W-1:0]  first_word, pass_word, out_word;
  code_mode_e         mode;

  assign raw = {wr_ni, load_ni, sel_a_ni, sel_b_ni, sel_c_ni, data_i};

  nib_dac_sync #(
    .W(SYN_W), .STAGES(SYNC_STAGES), .RST_V(SYN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {s_wr_n, s_load_n, s_sel_n, s_data} = syn;

  nib_dac_rank1 #(
    .NIB_W(NIB_W), .NUM_NIB(NUM_NIB)
  ) u_rank1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_ni (s_wr_n),
    .sel_ni(s_sel_n),
    .data_i(s_data),
    .word_o(first_word),
    .pass_o(pass_word)
  );

  nib_dac_rank2 #(
    .WORD_W(WORD_W)
  ) u_rank2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_ni  (s_wr_n),
    .load_ni(s_load_n),
    .pass_i (pass_word),
    .out_o  (out_word),
    .upd_o  (upd_o)
  );

  assign mode = code_mode_e'(code_mode_i);

  always_comb begin
    code_o = out_word;
    if (mode == CODE_TWOS) code_o[WORD_W-1] = ~out_word[WORD_W-1];
  end

  // R7
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o[WORD_W-2:0] == out_word[WORD_W-2:0]);

  // R1
  first_rank_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> first_word == '0);
endmodule

// File: tb/nib_dac_front_test.sv
module nib_dac_front_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1, sa_n = 1'b1, sb_n = 1'b1, sc_n = 1'b1, ld_n = 1'b1;
  logic [11:0] data = '0;
  logic [1:0]  mode = 2'b00;
  logic [11:0] code;
  logic        upd;

  int vecs = 0, miss = 0, upd_cnt = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  nib_dac_front uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n),
    .sel_a_ni(sa_n), .sel_b_ni(sb_n), .sel_c_ni(sc_n), .load_ni(ld_n),
    .data_i(data), .code_mode_i(mode), .code_o(code), .upd_o(upd)
  );

  always @(negedge clk) if (upd) upd_cnt++;

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic a, b, c, l, input logic [11:0] d);
    @(negedge clk); sa_n = a; sb_n = b; sc_n = c; ld_n = l; data = d;
    @(negedge clk); wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk); sa_n = 1'b1; sb_n = 1'b1; sc_n = 1'b1; ld_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 code in reset", code, 12'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 code after reset", code, 12'h000);
    check("R1 no upd after reset", upd_cnt, 0);
  endtask

  task automatic t_nibbles_then_load();
    int c0 = upd_cnt;
    strobe(0, 1, 1, 1, 12'hA00);
    strobe(1, 0, 1, 1, 12'h0B0);
    strobe(1, 1, 0, 1, 12'h00C);
    check("R4 no output change w/o load", code, 12'h000);
    check("R4 no upd w/o load", upd_cnt - c0, 0);
    strobe(1, 1, 1, 0, 12'hFFF);
    check("R2 R4 load assembled word", code, 12'hABC);
    check("R8 one upd on load", upd_cnt - c0, 1);
    strobe(1, 0, 1, 1, 12'h555);
    strobe(1, 1, 1, 0, 12'h000);
    check("R2 only nibble B replaced", code, 12'hA5C);
  endtask

  task automatic t_strobe_idle();
    int c0 = upd_cnt;
    @(negedge clk); sa_n = 0; sb_n = 0; sc_n = 0; ld_n = 0; data = 12'h123;
    repeat (6) @(negedge clk);
    data = 12'hFED;
    repeat (6) @(negedge clk);
    check("R3 code held with strobe high", code, 12'hA5C);
    sa_n = 1; sb_n = 1; sc_n = 1; ld_n = 1;
    repeat (4) @(negedge clk);
    strobe(1, 1, 1, 0, 12'h000);
    check("R3 nibbles untouched", code, 12'hA5C);
    check("R8 no upd on same reload", upd_cnt - c0, 0);
  endtask

  task automatic t_combined();
    int c0;
    strobe(0, 1, 1, 1, 12'h5FF);
    strobe(1, 0, 1, 1, 12'hFAF);
    c0 = upd_cnt;
    strobe(1, 1, 0, 0, 12'hFF7);
    check("R5 final nibble with load", code, 12'h5A7);
    check("R5 single output change", upd_cnt - c0, 1);
  endtask

  task automatic t_transparent();
    @(negedge clk); data = 12'h3C9;
    @(negedge clk); wr_n = 0; sa_n = 0; sb_n = 0; sc_n = 0; ld_n = 0;
    repeat (5) @(negedge clk);
    check("R6 transparent value", code, 12'h3C9);
    data = 12'h9E1;
    repeat (5) @(negedge clk);
    check("R6 transparent tracks bus", code, 12'h9E1);
    wr_n = 1;
    @(negedge clk); sa_n = 1; sb_n = 1; sc_n = 1; ld_n = 1;
    data = 12'h000;
    repeat (5) @(negedge clk);
    check("R6 held after release", code, 12'h9E1);
  endtask

  task automatic t_latency();
    @(negedge clk); data = 12'h246;
    repeat (4) @(negedge clk);
    wr_n = 0; sa_n = 0; sb_n = 0; sc_n = 0; ld_n = 0;
    @(negedge clk);
    check("R9 old after 1 edge", code, 12'h9E1);
    @(negedge clk);
    check("R9 old after 2 edges", code, 12'h9E1);
    @(negedge clk);
    check("R9 new after 3 edges", code, 12'h246);
    wr_n = 1;
    @(negedge clk); sa_n = 1; sb_n = 1; sc_n = 1; ld_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_modes();
    strobe(0, 0, 0, 0, 12'h800);
    mode = 2'b00; #1 check("R7 straight 0x800", code, 12'h800);
    mode = 2'b01; #1 check("R7 offset 0x800", code, 12'h800);
    mode = 2'b10; #1 check("R7 twos 0x800", code, 12'h000);
    mode = 2'b11; #1 check("R7 spare 0x800", code, 12'h800);
    mode = 2'b00;
    strobe(0, 0, 0, 0, 12'h7FF);
    mode = 2'b10; #1 check("R7 twos 0x7FF", code, 12'hFFF);
    mode = 2'b00; #1 check("R7 straight 0x7FF", code, 12'h7FF);
  endtask

  initial begin
    t_reset();
    t_nibbles_then_load();
    t_strobe_idle();
    t_combined();
    t_transparent();
    t_latency();
    t_modes();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vecs++;
      miss++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule